// File: doc/BRIEF.md
# Global-Clock Transparent Latch Emulator

This block reproduces the behaviour of a level-sensitive storage latch, with per-bit set and clear overrides, in a design where every register runs on one fast global clock. It has no real latch. A register on the global clock keeps the previous output word, and combinational logic picks between the live data word and that kept word.

While the gate input is at its active level, the output passes the data word straight through in the same cycle. While the gate is inactive, the output repeats the word held from the previous global cycle. Per-bit set and clear inputs are then laid over the selected word, and clear has the final say.

The polarities of the gate, set and clear inputs are chosen separately by parameters. Two further parameters give the power-up content of the held word and say which of its bits have a defined power-up value. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `latch_emu`

## Requirements
- R1: On every global clock edge outside reset, the held word takes the value the output had in the cycle before that edge, so any output value (including one made by set or clear) persists.
- R2: With the gate active and no set or clear bit active, the output equals the data word in the same cycle.
- R3: With the gate inactive and no set or clear bit active, the output equals the held word, so it does not follow changes on the data word.
- R4: Parameter EN_ACTIVE_HIGH selects the gate polarity: 1 means the gate is active when gate_i is 1; 0 means it is active when gate_i is 0.
- R5: An active set bit forces the matching output bit to 1 whether the gate is active or not. Parameter SET_ACTIVE_HIGH selects the set polarity (1: a 1 on set_i is active; 0: a 0 is active).
- R6: An active clear bit forces the matching output bit to 0, and it wins over an active set bit on the same position.
- R7: Parameter CLR_ACTIVE_HIGH selects the clear polarity (1: a 1 on clr_i is active; 0: a 0 is active), independently of the set polarity.
- R8: At reset release, every held bit whose INIT_KNOWN bit is 1 holds the matching INIT_VALUE bit. Bits whose INIT_KNOWN bit is 0 get no reset and have an undefined power-up value.
- R9: rst_ni asserts reset asynchronously and is released two global clock edges after it rises. The pass-through and overlay logic keep working while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast global clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Latch gate, polarity set by EN_ACTIVE_HIGH |
| data_i | input | WIDTH | Data word passed through while the gate is active |
| set_i | input | WIDTH | Per-bit set, polarity set by SET_ACTIVE_HIGH |
| clr_i | input | WIDTH | Per-bit clear, polarity set by CLR_ACTIVE_HIGH |
| q_o | output | WIDTH | Emulated latch output |

## Verification
The held word is the only state. If it is wrong, q_o shows the error in the first cycle in which the gate is inactive and no set or clear bit covers the affected position, and the error stays until the gate opens or an override covers that bit. A polarity mistake shows in the same cycle as the stimulus, because the output is combinational in the inputs. A held word that fails to capture an override shows one cycle after the override is removed. The bench runs two instances with opposite polarities on the same logical stimulus, so that an inverted normalizer shows up as a mismatch on one of them.

// File: rtl/lemu_pkg.sv
package lemu_pkg;

  // Map a raw control vector of either polarity to active-high form.
  function automatic logic norm_bit(input bit active_high, input logic raw);
    return active_high ? raw : ~raw;
  endfunction

  // Encodes the bit positions with a defined power-up value.
  typedef enum logic [0:0] {
    INIT_UNDEF = 1'b0,
    INIT_DEF   = 1'b1
  } init_kind_e;

endpackage

// File: rtl/lemu_rst_sync.sv
module lemu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

  // R9: the synchronized reset stays low for as long as the raw reset is low
  a_r9_sync_follows_assert: assert property (
    @(posedge clk_i) !rst_ni |-> !rst_sync_no
  ) else $error("a_r9_sync_follows_assert");

endmodule

// File: rtl/lemu_pol_norm.sv
module lemu_pol_norm #(
  parameter int unsigned WIDTH       = 8,
  parameter bit          ACTIVE_HIGH = 1'b1
) (
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] act_o
);

  import lemu_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign act_o[i] = norm_bit(ACTIVE_HIGH, raw_i[i]);
  end

endmodule

// File: rtl/lemu_hold_reg.sv
module lemu_hold_reg #(
  parameter int unsigned      WIDTH      = 8,
  parameter logic [WIDTH-1:0] INIT_VALUE = '0,
  parameter logic [WIDTH-1:0] INIT_KNOWN = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  import lemu_pkg::*;

  logic [WIDTH-1:0] hold_d;
  logic [WIDTH-1:0] hold_q;

  // The next value is always the current output word: capture every cycle.
  always_comb begin
    hold_d = d_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (init_kind_e'(INIT_KNOWN[i]) == INIT_DEF) begin : g_reset
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hold_q[i] <= INIT_VALUE[i];
        end else begin
          hold_q[i] <= hold_d[i];
        end
      end
    end else begin : g_noreset
      always_ff @(posedge clk_i) begin
        hold_q[i] <= hold_d[i];
      end
    end
  end

  assign q_o = hold_q;

  // Set once the register has captured at least one edge outside reset.
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
    end
  end

  // R1: the held word equals the previous cycle's output
  a_r1_hold_tracks: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (q_o == $past(d_i))
  ) else $error("a_r1_hold_tracks");

  // R8: defined bits carry their power-up value at reset release
  a_r8_init_value: assert property (
    @(posedge clk_i) $rose(rst_ni) |-> ((q_o & INIT_KNOWN) == (INIT_VALUE & INIT_KNOWN))
  ) else $error("a_r8_init_value");

endmodule

// File: rtl/lemu_overlay.sv
module lemu_overlay #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             gate_act_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] held_i,
  input  logic [WIDTH-1:0] set_act_i,
  input  logic [WIDTH-1:0] clr_act_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] picked;
  logic [WIDTH-1:0] with_set;

  // Stage order matters: pick, then set, then clear (clear dominates).
  always_comb begin
    picked   = gate_act_i ? data_i : held_i;
    with_set = picked | set_act_i;
    q_o      = with_set & ~clr_act_i;
  end

endmodule

// File: rtl/latch_emu.sv
module latch_emu #(
  parameter int unsigned      WIDTH           = 8,
  parameter bit               EN_ACTIVE_HIGH  = 1'b1,
  parameter bit               SET_ACTIVE_HIGH = 1'b1,
  parameter bit               CLR_ACTIVE_HIGH = 1'b1,
  parameter logic [WIDTH-1:0] INIT_VALUE      = '0,
  parameter logic [WIDTH-1:0] INIT_KNOWN      = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic             rst_sync_n;
  logic             gate_act;
  logic [WIDTH-1:0] set_act;
  logic [WIDTH-1:0] clr_act;
  logic [WIDTH-1:0] held;
  logic [WIDTH-1:0] q_int;

  lemu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  lemu_pol_norm #(.WIDTH(1), .ACTIVE_HIGH(EN_ACTIVE_HIGH)) u_gate_norm (
    .raw_i (gate_i),
    .act_o (gate_act)
  );

  lemu_pol_norm #(.WIDTH(WIDTH), .ACTIVE_HIGH(SET_ACTIVE_HIGH)) u_set_norm (
    .raw_i (set_i),
    .act_o (set_act)
  );

  lemu_pol_norm #(.WIDTH(WIDTH), .ACTIVE_HIGH(CLR_ACTIVE_HIGH)) u_clr_norm (
    .raw_i (clr_i),
    .act_o (clr_act)
  );

  lemu_hold_reg #(
    .WIDTH      (WIDTH),
    .INIT_VALUE (INIT_VALUE),
    .INIT_KNOWN (INIT_KNOWN)
  ) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    (q_int),
    .q_o    (held)
  );

  lemu_overlay #(.WIDTH(WIDTH)) u_overlay (
    .gate_act_i (gate_act),
    .data_i     (data_i),
    .held_i     (held),
    .set_act_i  (set_act),
    .clr_act_i  (clr_act),
    .q_o        (q_int)
  );

  assign q_o = q_int;

  // Set after the first edge captured outside reset.
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
    end
  end

  // R2: transparent pass-through while the gate is active
  a_r2_transparent: assert property (
    @(posedge clk_i) disable iff (!rst_sync_n)
    (gate_act && set_act == '0 && clr_act == '0) |-> (q_o == data_i)
  ) else $error("a_r2_transparent");

  // R3: with the gate closed and no override, the output repeats last cycle
  a_r3_hold_output: assert property (
    @(posedge clk_i) disable iff (!rst_sync_n)
    (past_ok_q && !gate_act && set_act == '0 && clr_act == '0) |-> (q_o == $past(q_o))
  ) else $error("a_r3_hold_output");

  // R5: an active set bit without clear drives a 1
  a_r5_set_forces_one: assert property (
    @(posedge clk_i) disable iff (!rst_sync_n)
    (set_act != '0) |-> ((q_o & set_act & ~clr_act) == (set_act & ~clr_act))
  ) else $error("a_r5_set_forces_one");

  // R6: an active clear bit drives a 0, even when set is also active
  a_r6_clear_wins: assert property (
    @(posedge clk_i) disable iff (!rst_sync_n)
    (clr_act != '0) |-> ((q_o & clr_act) == '0)
  ) else $error("a_r6_clear_wins");

endmodule

// File: tb/latch_emu_bench.sv
module latch_emu_bench;

  localparam int W = 8;
  localparam logic [W-1:0] HI_INIT  = 8'hA5;
  localparam logic [W-1:0] HI_KNOWN = 8'hF0;
  localparam logic [W-1:0] LO_INIT  = 8'h3C;
  localparam logic [W-1:0] LO_KNOWN = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Logical (active-high) stimulus, converted per instance.
  logic         g;
  logic [W-1:0] d, s, c;
  logic [W-1:0] q_hi, q_lo;

  latch_emu #(
    .WIDTH(W), .EN_ACTIVE_HIGH(1'b1), .SET_ACTIVE_HIGH(1'b1), .CLR_ACTIVE_HIGH(1'b1),
    .INIT_VALUE(HI_INIT), .INIT_KNOWN(HI_KNOWN)
  ) u_latch_emu (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(g), .data_i(d), .set_i(s), .clr_i(c), .q_o(q_hi)
  );

  latch_emu #(
    .WIDTH(W), .EN_ACTIVE_HIGH(1'b0), .SET_ACTIVE_HIGH(1'b0), .CLR_ACTIVE_HIGH(1'b0),
    .INIT_VALUE(LO_INIT), .INIT_KNOWN(LO_KNOWN)
  ) u_latch_emu_lo (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(~g), .data_i(d), .set_i(~s), .clr_i(~c), .q_o(q_lo)
  );

  typedef struct {
    logic [W-1:0] exp_hi;
    logic [W-1:0] exp_lo;
    logic [W-1:0] mask_hi;
    logic [W-1:0] mask_lo;
    string        tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state from the requirements.
  logic [W-1:0] mh_hi = HI_INIT, mh_lo = LO_INIT;
  logic [W-1:0] kn_hi = HI_KNOWN, kn_lo = LO_KNOWN;

  task automatic drive(input logic gg, input logic [W-1:0] dd, input logic [W-1:0] ss,
                       input logic [W-1:0] cc, input bit upd, input string tag);
    item_t it;
    logic [W-1:0] nk_hi, nk_lo;
    @(negedge clk);
    g = gg; d = dd; s = ss; c = cc;
    it.exp_hi = ((gg ? dd : mh_hi) | ss) & ~cc;
    it.exp_lo = ((gg ? dd : mh_lo) | ss) & ~cc;
    nk_hi = gg ? '1 : (kn_hi | ss | cc);
    nk_lo = gg ? '1 : (kn_lo | ss | cc);
    it.mask_hi = nk_hi;
    it.mask_lo = nk_lo;
    it.tag = tag;
    sb.push_back(it);
    if (upd) begin
      mh_hi = it.exp_hi; mh_lo = it.exp_lo;
      kn_hi = nk_hi; kn_lo = nk_lo;
    end
  endtask

  // Monitor: pops expected items well after inputs settle, before the next edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (((q_hi ^ it.exp_hi) & it.mask_hi) != '0) begin
          errors++;
          $display("FAIL %s active-high instance: actual=%h expected=%h mask=%h",
                   it.tag, q_hi, it.exp_hi, it.mask_hi);
        end
        checks++;
        if (((q_lo ^ it.exp_lo) & it.mask_lo) != '0) begin
          errors++;
          $display("FAIL %s active-low instance: actual=%h expected=%h mask=%h",
                   it.tag, q_lo, it.exp_lo, it.mask_lo);
        end
      end
    end
  end

  initial begin
    g = 1'b0; d = '0; s = '0; c = '0;
    // R9: pass-through works while reset is asserted; held state not updated in the model
    drive(1'b1, 8'h77, 8'h00, 8'h00, 1'b0, "R9 transparent in reset");
    drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R9 idle in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: defined bits show the power-up value after release
    kn_hi = HI_KNOWN; kn_lo = LO_KNOWN;
    mh_hi = HI_INIT;  mh_lo = LO_INIT;
    drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R8 init value");
    drive(1'b0, 8'hFF, 8'h00, 8'h00, 1'b1, "R3 R4 closed gate ignores data");
    drive(1'b1, 8'h5A, 8'h00, 8'h00, 1'b1, "R2 R4 transparent 5A");
    drive(1'b1, 8'hC3, 8'h00, 8'h00, 1'b1, "R2 transparent C3");
    drive(1'b0, 8'hFF, 8'h00, 8'h00, 1'b1, "R3 hold after close");
    drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R1 R3 hold persists");
    drive(1'b0, 8'h00, 8'h0C, 8'h00, 1'b1, "R5 set while closed");
    drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R1 set value retained");
    drive(1'b0, 8'h00, 8'h00, 8'h81, 1'b1, "R6 R7 clear while closed");
    drive(1'b0, 8'h00, 8'h30, 8'h30, 1'b1, "R6 clear wins over set");
    drive(1'b1, 8'hF0, 8'h0F, 8'h3C, 1'b1, "R5 R6 overlay while open");
    drive(1'b0, 8'h11, 8'h00, 8'h00, 1'b1, "R1 overlay result held");
    drive(1'b1, 8'h00, 8'h00, 8'hFF, 1'b1, "R7 clear all while open");
    drive(1'b0, 8'hAA, 8'h00, 8'h00, 1'b1, "R3 hold zero");
    drive(1'b1, 8'h96, 8'h00, 8'h00, 1'b1, "R2 R4 transparent 96");
    drive(1'b0, 8'h69, 8'h00, 8'h00, 1'b1, "R3 R4 hold 96");
    drive(1'b0, 8'h69, 8'hF0, 8'h0F, 1'b1, "R5 R7 split set and clear");
    drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R1 split result held");
    // R9: asynchronous assertion restores the power-up value of defined bits
    @(negedge clk);
    rst_n = 1'b0;
    g = 1'b0; d = '0; s = '0; c = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mh_hi = HI_INIT; mh_lo = LO_INIT;
    kn_hi = HI_KNOWN; kn_lo = LO_KNOWN;
    drive(1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R8 R9 init after second reset");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule